// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for a precision time protocol clock. On every clock edge on which the time-sync enable is high, it adds a fixed-point increment to the count. The increment has 32 integer bits and 32 fractional bits. A 32-bit fractional accumulator holds the sub-nanosecond remainder, and its carry feeds the integer sum. Because the count is a full 64 bits of nanoseconds, it needs no separate cycle counter and no overflow handling. The live count also appears on a wide output for the local timestamping logic.

Software reaches the block through a plain 32-bit register port with four word addresses. Reading the low time word captures the whole 64-bit time, and the following high-word read returns the captured upper half. Writes to the time and to the increment are staged in the low word and applied as one 64-bit value when the high word is written.

When software has not overridden the increment, it follows a link-speed input. Software can write its own increment to trim the frequency. That override holds until the link speed changes.

Top module: `tod_frac_clock`

## Requirements
- R1: After reset, `time_now` and `reg_rdata` are zero.
- R2: On each edge with `sync_en` high and no time load, `time_now` advances by the integer part of the increment plus the carry out of the 32-bit fractional accumulator. For example, ten ticks of 0x1_9999_9999 from a fresh load advance the time by 15 ns.
- R3: While `sync_en` is low, `time_now` holds its value.
- R4: When no override is active, the increment follows `link_speed` one edge later. The encodings are:
  - 2 (1G) gives 0x20_0000_0000.
  - 3 (10G) gives 0x3_3333_3333.
  - 4 (40G) gives 0x1_9999_9999.
  - 0 (no link) and any unused code give 0x1_9999_9999.
- R5: With `link_speed` = 1 (100M), the default increment is zero, so the time does not advance even when `sync_en` is high.
- R6: A read of address 0 returns bits 31:0 of the time as it stood at that edge and captures all 64 bits. A later read of address 1 returns bits 63:32 of that capture, even if the live time has carried into the upper half in between.
- R7: A write to address 0 only stages the low time word and leaves `time_now` unchanged. A write to address 1 loads {written word, staged word} into the time at that same edge.
- R8: A time load clears the fractional accumulator.
- R9: A write to address 2 only stages the low increment word and leaves the active increment unchanged. A write to address 3 makes {written word, staged word} the active increment at that edge.
- R10: A software increment stays active across later edges until `link_speed` changes. A change then reloads the default increment for the new speed.
- R11: A read of address 2 returns the low word of the active increment, and a read of address 3 returns the high word. Every read returns its data on `reg_rdata` one edge after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Time-sync enable; the count advances only while high |
| link_speed | input | 3 | Link speed code that selects the default increment |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 time low, 1 time high, 2 increment low, 3 increment high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one edge after the read strobe |
| time_now | output | 64 | Live nanosecond time |

## Verification
The assertions rely on a few properties of the inputs. A read strobe and a write strobe never arrive in the same cycle. The register address is held for the whole strobe cycle. The time stays far below the 64-bit wrap point, so the monotonic-advance check holds. The bench drives every access through tasks that raise exactly one strobe for one cycle. It loads only small time values, or values just below a 32-bit word boundary, and it changes `link_speed` only between accesses.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W = 32;
  localparam int FRAC_W = 32;
  localparam int INC_W  = 64;
  localparam int TIME_W = 64;
  localparam int SPD_W  = 3;

  typedef enum logic [SPD_W-1:0] {
    SPD_NONE = 3'd0,
    SPD_100M = 3'd1,
    SPD_1G   = 3'd2,
    SPD_10G  = 3'd3,
    SPD_40G  = 3'd4
  } speed_e;

  typedef enum logic [1:0] {
    A_TIME_LO = 2'd0,
    A_TIME_HI = 2'd1,
    A_INC_LO  = 2'd2,
    A_INC_HI  = 2'd3
  } addr_e;

  localparam logic [INC_W-1:0] INC_1P6 = 64'h0000_0001_9999_9999;
  localparam logic [INC_W-1:0] INC_3P2 = 64'h0000_0003_3333_3333;
  localparam logic [INC_W-1:0] INC_32  = 64'h0000_0020_0000_0000;

  // Default per-tick increment for a given link speed code.
  function automatic logic [INC_W-1:0] default_inc(input logic [SPD_W-1:0] spd);
    case (spd)
      SPD_100M: default_inc = '0;
      SPD_1G:   default_inc = INC_32;
      SPD_10G:  default_inc = INC_3P2;
      default:  default_inc = INC_1P6;
    endcase
  endfunction
endpackage

// File: rtl/tod_inc_sel.sv
module tod_inc_sel
  import tod_pkg::*;
#(
  parameter int IW = INC_W,
  parameter int SW = SPD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] link_speed,
  input  logic          inc_load,
  input  logic [IW-1:0] inc_val,
  output logic [IW-1:0] active_inc
);
  logic [SW-1:0] speed_q;
  logic          ovr_q;
  logic          speed_chg;
  logic [IW-1:0] dflt;

  assign dflt      = default_inc(link_speed);
  assign speed_chg = (link_speed != speed_q);

  // Software write wins; otherwise a speed change or no override
  // leaves the increment tracking the default.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_inc <= '0;
      ovr_q      <= 1'b0;
      speed_q    <= '0;
    end else begin
      speed_q <= link_speed;
      if (inc_load) begin
        active_inc <= inc_val;
        ovr_q      <= 1'b1;
      end else if (speed_chg || !ovr_q) begin
        active_inc <= dflt;
        ovr_q      <= 1'b0;
      end
    end
  end

  // R9: an increment write is active after its edge
  assert_inc_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inc_load |=> active_inc == $past(inc_val));

  // R10: a speed change without a write reloads the default
  assert_speed_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_load && speed_chg) |=> active_inc == default_inc($past(link_speed)));
endmodule

// File: rtl/tod_accum.sv
module tod_accum
  import tod_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int IW = INC_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] inc,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] ns
);
  localparam int IPW = IW - FW;

  logic [FW-1:0]  frac_q;
  logic [FW:0]    frac_sum;
  logic [IPW-1:0] inc_int;
  logic [TW-1:0]  ns_next;

  assign inc_int  = inc[IW-1:FW];
  assign frac_sum = {1'b0, frac_q} + {1'b0, inc[FW-1:0]};
  assign ns_next  = ns + {{(TW-IPW){1'b0}}, inc_int} + {{(TW-1){1'b0}}, frac_sum[FW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns     <= '0;
      frac_q <= '0;
    end else if (load) begin
      ns     <= load_val;
      frac_q <= '0;
    end else if (en) begin
      ns     <= ns_next;
      frac_q <= frac_sum[FW-1:0];
    end
  end

  // R3 / R5: no advance when disabled or with a zero increment
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (!en || inc == '0)) |=> ns == $past(ns));

  // R7 / R8: a load sets the time and clears the fraction
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns == $past(load_val)) && (frac_q == '0));

  // R2: the count never moves backwards while ticking
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ns >= $past(ns));
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int TW = TIME_W,
  parameter int IW = INC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [WW-1:0] reg_wdata,
  output logic [WW-1:0] reg_rdata,
  input  logic [TW-1:0] time_ns,
  input  logic [IW-1:0] active_inc,
  output logic          time_load,
  output logic [TW-1:0] time_val,
  output logic          inc_load,
  output logic [IW-1:0] inc_val
);
  logic [WW-1:0] time_lo_stg;
  logic [WW-1:0] inc_lo_stg;
  logic [TW-1:0] snap_q;

  // High-word writes commit the staged low word together with the new high word.
  assign time_load = reg_wr && (reg_addr == A_TIME_HI);
  assign inc_load  = reg_wr && (reg_addr == A_INC_HI);
  assign time_val  = {reg_wdata, time_lo_stg};
  assign inc_val   = {reg_wdata, inc_lo_stg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_lo_stg <= '0;
      inc_lo_stg  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_TIME_LO) time_lo_stg <= reg_wdata;
      if (reg_addr == A_INC_LO)  inc_lo_stg  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q    <= '0;
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_TIME_LO: begin
          snap_q    <= time_ns;
          reg_rdata <= time_ns[WW-1:0];
        end
        A_TIME_HI: reg_rdata <= snap_q[TW-1:TW-WW];
        A_INC_LO:  reg_rdata <= active_inc[WW-1:0];
        default:   reg_rdata <= active_inc[IW-1:IW-WW];
      endcase
    end
  end

  // R6: the low read returns the time at the strobe edge
  assert_low_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TIME_LO) |=> reg_rdata == $past(time_ns[WW-1:0]));

  // R6: the high read returns the captured upper half
  assert_high_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TIME_HI) |=> reg_rdata == $past(snap_q[TW-1:TW-WW]));

  // R11: the data word holds when no read is issued
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/tod_frac_clock.sv
module tod_frac_clock
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_en,
  input  logic [SPD_W-1:0]  link_speed,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [TIME_W-1:0] time_now
);
  logic              time_load;
  logic [TIME_W-1:0] time_val;
  logic              inc_load;
  logic [INC_W-1:0]  inc_val;
  logic [INC_W-1:0]  active_inc;

  tod_regif #(.WW(WORD_W), .TW(TIME_W), .IW(INC_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_ns(time_now), .active_inc(active_inc),
    .time_load(time_load), .time_val(time_val),
    .inc_load(inc_load), .inc_val(inc_val)
  );

  tod_inc_sel #(.IW(INC_W), .SW(SPD_W)) u_inc (
    .clk(clk), .rst_n(rst_n), .link_speed(link_speed),
    .inc_load(inc_load), .inc_val(inc_val), .active_inc(active_inc)
  );

  tod_accum #(.TW(TIME_W), .IW(INC_W), .FW(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .inc(active_inc),
    .load(time_load), .load_val(time_val), .ns(time_now)
  );

  // R1: reset clears the time
  assert_reset_R1: assert property (@(posedge clk) !rst_n |=> time_now == '0);
endmodule

// File: tb/tod_frac_clock_test.sv
module tod_frac_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_en = 1'b0;
  logic [2:0]  link_speed = 3'd4;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_frac_clock uut (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .link_speed(link_speed),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_now(time_now)
  );

  // speed code -> expected default increment
  localparam int NV = 6;
  localparam logic [66:0] SPEED_TAB [NV] = '{
    {3'd2, 64'h0000_0020_0000_0000},
    {3'd3, 64'h0000_0003_3333_3333},
    {3'd4, 64'h0000_0001_9999_9999},
    {3'd1, 64'h0000_0000_0000_0000},
    {3'd0, 64'h0000_0001_9999_9999},
    {3'd6, 64'h0000_0001_9999_9999}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_inc(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd_reg(2'd2, lo);
    rd_reg(2'd3, hi);
    v = {hi, lo};
  endtask

  task automatic load_time(input logic [63:0] v);
    wr_reg(2'd0, v[31:0]);
    wr_reg(2'd1, v[63:32]);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    sync_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    sync_en = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [63:0] v, t0, snap;
    logic [31:0] lo, hi;

    repeat (3) @(negedge clk);
    check("R1 reset time", time_now, 64'd0);
    check("R1 reset rdata", {32'd0, reg_rdata}, 64'd0);
    rst_n = 1'b1;

    // R4 / R5: walk the speed table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      link_speed = SPEED_TAB[i][66:64];
      repeat (2) @(negedge clk);
      rd_inc(v);
      check($sformatf("R4 R11 default inc code %0d", SPEED_TAB[i][66:64]), v, SPEED_TAB[i][63:0]);
    end

    // R5: a zero increment stops the clock
    link_speed = 3'd1;
    repeat (2) @(negedge clk);
    t0 = time_now;
    run_ticks(6);
    check("R5 100M clock stopped", time_now, t0);

    // R2 with an exact 32 ns step
    link_speed = 3'd2;
    repeat (2) @(negedge clk);
    load_time(64'd1000);
    check("R7 time load", time_now, 64'd1000);
    run_ticks(7);
    check("R2 32ns x7", time_now, 64'd1224);

    // R3: disabled clock holds
    t0 = time_now;
    repeat (5) @(negedge clk);
    check("R3 hold while disabled", time_now, t0);

    // R2 / R8: fractional carry and clear on load
    link_speed = 3'd4;
    repeat (2) @(negedge clk);
    load_time(64'd500);
    run_ticks(5);
    check("R2 1.6ns x5", time_now, 64'd507);
    load_time(64'd2000);
    run_ticks(10);
    check("R8 fraction cleared by load, 1.6ns x10", time_now, 64'd2015);

    // R7: the low word alone does not load
    t0 = time_now;
    wr_reg(2'd0, 32'hDEAD_0000);
    check("R7 low write staged only", time_now, t0);
    wr_reg(2'd1, 32'h0000_0007);
    check("R7 high write loads", time_now, 64'h0000_0007_DEAD_0000);

    // R6: coherent snapshot across a carry into the high word
    link_speed = 3'd2;
    repeat (2) @(negedge clk);
    load_time(64'h0000_0001_FFFF_FFC0);
    @(negedge clk);
    sync_en = 1'b1; reg_rd = 1'b1; reg_addr = 2'd0;
    snap = time_now;
    @(negedge clk);
    reg_rd = 1'b0;
    lo = reg_rdata;
    repeat (3) @(negedge clk);
    sync_en = 1'b0;
    rd_reg(2'd1, hi);
    check("R6 low read", {32'd0, lo}, {32'd0, snap[31:0]});
    check("R6 high read from snapshot", {32'd0, hi}, {32'd0, snap[63:32]});
    check("R6 live time carried", {32'd0, time_now[63:32]}, 64'd2);

    // R9: increment staging
    wr_reg(2'd2, 32'h0000_1234);
    rd_inc(v);
    check("R9 low inc write staged only", v, 64'h0000_0020_0000_0000);
    wr_reg(2'd3, 32'h0000_0005);
    rd_inc(v);
    check("R9 R11 inc write applied", v, 64'h0000_0005_0000_1234);

    // R10: override persists, then a speed change reloads
    repeat (4) @(negedge clk);
    rd_inc(v);
    check("R10 override persists", v, 64'h0000_0005_0000_1234);
    load_time(64'd0);
    run_ticks(4);
    check("R2 override step x4", time_now, 64'd20);
    link_speed = 3'd3;
    repeat (2) @(negedge clk);
    rd_inc(v);
    check("R10 speed change reloads default", v, 64'h0000_0003_3333_3333);

    finish_up();
  end
endmodule